// File: doc/BRIEF.md
# PWM Time-Base Counter with Phase Synchronisation

This block is the timing heart of a pulse-width modulator. A 16-bit counter runs in one of three stepping modes (rising sawtooth, falling sawtooth, or triangle) against a period value. The period is buffered: software writes a staging copy, and the counter takes that copy as its working limit only when the count passes through zero. The working limit is therefore never replaced in the middle of a cycle. The block emits a strobe whenever the count equals zero, the working period, or either of two compare values. It also reports which way the counter is currently moving.

Several of these units can be chained so that their phases stay aligned. Each unit accepts a sync pulse, either from its input pin or from a software write that asks for one. When phase loading is enabled, a sync pulse forces a programmed phase value into the counter. A selectable sync output forwards one of three sources to the next unit in the chain, or it can be turned off. Registers are written through a plain address/data strobe port and take effect on the next clock.

Top module: `pwm_timebase`

## Requirements
- R1: The mode field is bits [1:0] of the control register at address 0: 0 counts up, 1 counts down, 2 counts up-down, 3 holds the count. Outside sync, zero and period turns, an up count rises by one per clock and a down count falls by one.
- R2: In up mode, a count at or above the working period (and not zero) goes to 0 on the next clock. In down mode, a count of 0 reloads the staging period on the next clock. In up and up-down modes, a count of 0 goes to 1, or stays 0 when the staging period is 0.
- R3: Writes to address 1 set the staging period. The working period takes the staging value on every clock edge at which the count is 0.
- R4: In up-down mode, a rising count at or above a non-zero working period turns down and decrements. A count of 0 turns the direction up. `dir_up` reads 1 in up mode, 0 in down mode, and the stored direction in up-down and hold modes.
- R5: `ev_zero`, `ev_prd`, `ev_cmpa` and `ev_cmpb` are high exactly in the cycles where `cnt` equals 0, the working period, compare A (address 3) and compare B (address 4) respectively.
- R6: When the phase-enable bit (bit 2 of address 0) is set, a sync event loads the phase register (address 2) into the counter on the next clock. This overrides the mode step and leaves the direction unchanged. With the bit clear, a sync event has no effect on the count.
- R7: A write to address 0 with bit 5 set is a sync event in that cycle, exactly like `sync_in`. Bit 5 is not stored. The phase-enable and phase values used are those held before the write.
- R8: Bits [4:3] of address 0 select `sync_out`: 0 forwards the current sync event (pin or software), 1 forwards `ev_zero`, 2 forwards `ev_cmpb`, 3 holds it low.
- R9: After reset, the count, all stored registers and the mode are 0, the stored direction is up, and the count stays at 0 until a non-zero period is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| sync_in | input | 1 | External sync pulse |
| cnt | output | 16 | Current count |
| dir_up | output | 1 | Count direction, 1 = rising |
| ev_zero | output | 1 | Count equals zero |
| ev_prd | output | 1 | Count equals working period |
| ev_cmpa | output | 1 | Count equals compare A |
| ev_cmpb | output | 1 | Count equals compare B |
| sync_out | output | 1 | Selected sync output |

## Verification
The functions most likely to collide are the sync phase load and the mode's own turn or wrap. The risky cycles are when the count sits at zero or at the period just as a sync arrives, and when a staging-period write lands on the same clock as a zero-crossing transfer. The bench moves sync pulses across every offset of a triangle cycle, and it fires a software sync while the counter turns. A behavioural model rebuilt in the bench predicts the count, direction, events and sync output on every clock. That model applies the rule that sync wins and that the transfer uses the staging value held before the write. A mismatch in any of those cycles is reported against the requirement it breaks.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         sync_in,
  output logic [W-1:0] cnt,
  output logic         dir_up,
  output logic         ev_zero,
  output logic         ev_prd,
  output logic         ev_cmpa,
  output logic         ev_cmpb,
  output logic         sync_out
);
  localparam logic [1:0] M_UP = 2'd0, M_DN = 2'd1, M_UD = 2'd2, M_HOLD = 2'd3;
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [1:0]   mode_r, sel_r;
  logic         phase_en_r, dir_r;
  logic [W-1:0] prd_sh, prd_act, phase_r, cmpa_r, cmpb_r;
  logic [W-1:0] cnt_nxt;
  logic         dir_nxt, sync_evt, sw_sync, at_zero, first_step;

  assign sw_sync    = wr_en && (wr_addr == 3'd0) && wr_data[5];
  assign sync_evt   = sync_in || sw_sync;
  assign at_zero    = (cnt == ZERO);
  assign first_step = (prd_sh == ZERO) ? ZERO : ONE;

  assign ev_zero = at_zero;
  assign ev_prd  = (cnt == prd_act);
  assign ev_cmpa = (cnt == cmpa_r);
  assign ev_cmpb = (cnt == cmpb_r);

  assign dir_up = (mode_r == M_UP) ? 1'b1 : (mode_r == M_DN) ? 1'b0 : dir_r;

  always_comb begin
    cnt_nxt = cnt;
    dir_nxt = dir_r;
    if (sync_evt && phase_en_r) begin
      cnt_nxt = phase_r;
    end else begin
      case (mode_r)
        M_UP: begin
          if (at_zero)             cnt_nxt = first_step;
          else if (cnt >= prd_act) cnt_nxt = ZERO;
          else                     cnt_nxt = cnt + ONE;
        end
        M_DN: begin
          if (at_zero) cnt_nxt = prd_sh;
          else         cnt_nxt = cnt - ONE;
        end
        M_UD: begin
          if (at_zero) begin
            cnt_nxt = first_step;
            dir_nxt = 1'b1;
          end else if (dir_r && cnt >= prd_act) begin
            cnt_nxt = cnt - ONE;
            dir_nxt = 1'b0;
          end else if (dir_r) begin
            cnt_nxt = cnt + ONE;
          end else begin
            cnt_nxt = cnt - ONE;
          end
        end
        default: cnt_nxt = cnt;
      endcase
    end
  end

  always_comb begin
    case (sel_r)
      2'd0:    sync_out = sync_evt;
      2'd1:    sync_out = ev_zero;
      2'd2:    sync_out = ev_cmpb;
      default: sync_out = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= ZERO;
      dir_r      <= 1'b1;
      prd_act    <= ZERO;
      prd_sh     <= ZERO;
      phase_r    <= ZERO;
      cmpa_r     <= ZERO;
      cmpb_r     <= ZERO;
      mode_r     <= M_UP;
      sel_r      <= 2'd0;
      phase_en_r <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      dir_r <= dir_nxt;
      if (at_zero) prd_act <= prd_sh;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin
            mode_r     <= wr_data[1:0];
            phase_en_r <= wr_data[2];
            sel_r      <= wr_data[4:3];
          end
          3'd1: prd_sh  <= wr_data;
          3'd2: phase_r <= wr_data;
          3'd3: cmpa_r  <= wr_data;
          3'd4: cmpb_r  <= wr_data;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic [W-1:0] cnt,
  input logic [W-1:0] prd_act,
  input logic [W-1:0] prd_sh,
  input logic [W-1:0] phase,
  input logic         phase_en,
  input logic         sync_evt,
  input logic [1:0]   sel,
  input logic         sync_out,
  input logic         dir_up
);
  p_up_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !sync_evt && cnt != '0 && cnt < prd_act) |=> cnt == W'($past(cnt) + W'(1)));

  p_up_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !sync_evt && cnt != '0 && cnt >= prd_act) |=> cnt == '0);

  p_down_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !sync_evt && cnt == '0) |=> cnt == $past(prd_sh));

  p_shadow_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |=> prd_act == $past(prd_sh));

  p_turn_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !sync_evt && cnt != '0 && dir_up && cnt >= prd_act) |=> (mode != 2'd2 || !dir_up));

  p_phase_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_evt && phase_en) |=> cnt == $past(phase));

  p_sync_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd3) |-> !sync_out);
endmodule

bind pwm_timebase pwm_timebase_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_r), .cnt(cnt), .prd_act(prd_act),
  .prd_sh(prd_sh), .phase(phase_r), .phase_en(phase_en_r), .sync_evt(sync_evt),
  .sel(sel_r), .sync_out(sync_out), .dir_up(dir_up)
);

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        sync_in = 1'b0;
  logic [15:0] cnt;
  logic        dir_up, ev_zero, ev_prd, ev_cmpa, ev_cmpb, sync_out;

  int checks = 0, fails = 0, cyc = 0;
  int m_cnt = 0, m_sh = 0, m_act = 0, m_ph = 0, m_ca = 0, m_cb = 0;
  int m_mode = 0, m_pe = 0, m_sel = 0, m_dir = 1;

  pwm_timebase dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_in(sync_in), .cnt(cnt), .dir_up(dir_up),
    .ev_zero(ev_zero), .ev_prd(ev_prd), .ev_cmpa(ev_cmpa), .ev_cmpb(ev_cmpb),
    .sync_out(sync_out));

  always #2 clk = ~clk;

  function automatic int sync_now();
    return (sync_in || (wr_en && wr_addr == 3'd0 && wr_data[5])) ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // reference model: one step per rising edge
  always @(posedge clk) begin
    int n, d, first;
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_sh = 0; m_act = 0; m_ph = 0; m_ca = 0; m_cb = 0;
      m_mode = 0; m_pe = 0; m_sel = 0; m_dir = 1;
    end else begin
      n = m_cnt; d = m_dir;
      first = (m_sh == 0) ? 0 : 1;
      if (sync_now() != 0 && m_pe != 0) n = m_ph;
      else if (m_mode == 0) n = (m_cnt == 0) ? first : (m_cnt >= m_act) ? 0 : m_cnt + 1;
      else if (m_mode == 1) n = (m_cnt == 0) ? m_sh : m_cnt - 1;
      else if (m_mode == 2) begin
        if (m_cnt == 0) begin n = first; d = 1; end
        else if (m_dir == 1 && m_cnt >= m_act) begin n = m_cnt - 1; d = 0; end
        else n = (m_dir == 1) ? m_cnt + 1 : m_cnt - 1;
      end
      if (m_cnt == 0) m_act = m_sh;
      m_cnt = n; m_dir = d;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_mode = wr_data[1:0]; m_pe = wr_data[2]; m_sel = wr_data[4:3]; end
          3'd1: m_sh = wr_data;
          3'd2: m_ph = wr_data;
          3'd3: m_ca = wr_data;
          3'd4: m_cb = wr_data;
          default: ;
        endcase
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    int ed, eso;
    if (cyc > 0) begin
      ed  = (m_mode == 0) ? 1 : (m_mode == 1) ? 0 : m_dir;
      eso = (m_sel == 0) ? sync_now() : (m_sel == 1) ? ((m_cnt == 0) ? 1 : 0)
          : (m_sel == 2) ? ((m_cnt == m_cb) ? 1 : 0) : 0;
      chk("R1 R2 R3 R6 R7 R9 cnt", int'(cnt), m_cnt);
      chk("R4 dir_up", int'(dir_up), ed);
      chk("R5 ev_zero", int'(ev_zero), (m_cnt == 0) ? 1 : 0);
      chk("R5 ev_prd", int'(ev_prd), (m_cnt == m_act) ? 1 : 0);
      chk("R5 ev_cmpa", int'(ev_cmpa), (m_cnt == m_ca) ? 1 : 0);
      chk("R5 ev_cmpb", int'(ev_cmpb), (m_cnt == m_cb) ? 1 : 0);
      chk("R8 sync_out", int'(sync_out), eso);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic wr(int a, int v);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(v);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(posedge clk); #1 sync_in = 1'b1;
    @(posedge clk); #1 sync_in = 1'b0;
  endtask

  initial begin
    idle(3);
    #1 rst_n = 1'b1;
    idle(4);                         // R9: held at zero with no period
    wr(1, 5); idle(20);              // R2 up wrap, R3 transfer
    wr(3, 2); wr(4, 4); idle(12);    // R5 compares
    wr(1, 3); idle(14);              // R3 staging change mid-cycle
    wr(0, 1); idle(14);              // R1/R2 down
    wr(1, 4); wr(0, 2); idle(24);    // R4 up-down
    pulse(); idle(5);                // R6 no effect without enable
    wr(2, 2); wr(0, 2 | 4);          // R6 phase enabled
    for (int k = 0; k < 10; k++) begin idle(k); pulse(); end
    wr(0, 2 | 4 | 32); idle(3);      // R7 software sync
    for (int k = 0; k < 8; k++) begin idle(k); wr(0, 2 | 4 | 32); end
    for (int s = 0; s < 4; s++) begin // R8 each source
      wr(0, 4 | (s << 3)); idle(9); pulse(); idle(3); wr(0, 4 | 32 | (s << 3)); idle(6);
    end
    wr(0, 1 | 4 | 8); idle(3); pulse(); idle(8);
    wr(2, 9); wr(0, 2 | 4); pulse(); idle(14); // phase above period
    wr(0, 4); pulse(); idle(10);
    wr(0, 3); idle(5); pulse(); idle(3);       // hold
    wr(1, 0); wr(0, 0); idle(16);              // period back to zero
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule